// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts hardware activity for profiling. It holds one clock-cycle counter and two event counters, each as wide as the data bus. Each event counter picks one line out of a vector of single-cycle activity pulses using an 8-bit code. A single control word holds every setting and all status. That word contains the run enable, the counter-clear strobes, a slow-rate option for the cycle counter, the interrupt enables, the sticky wrap flags and both event codes.

A small register bus with a write strobe and a 2-bit address reaches the control word and all three counters. Reads are combinational from the addressed register. Software clears a wrap flag by writing a one back into its bit. The interrupt line is high while any counter has both its wrap flag and its interrupt enable set.

Top module: `pmon_unit`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: While control bit 0 (run) is clear, no counter changes value, whatever the event inputs do.
- R3: A control write with bit 1 set zeroes both event counters at that clock edge. A control write with bit 2 set zeroes the cycle counter and its rate divider. Neither bit is stored, and both read back as 0. Neither strobe affects the other group of counters.
- R4: While run is set and control bit 3 is clear, the cycle counter adds one on every clock edge.
- R5: While run and bit 3 are both set, the cycle counter adds one once every 64 run edges, counted from its last clear.
- R6: Event counter 0 takes its code from control bits 12-19, and event counter 1 takes its code from bits 20-27. While run is set, a counter adds one on each edge where `evt_in[code]` is high. Both counters may use the same code.
- R7: Code 0xFF, or any code above 0x16, selects no event, so that counter holds its value.
- R8: When a counter steps from all-ones to zero, its wrap flag is set. The flags are bit 8 (event 0), bit 9 (event 1) and bit 10 (cycle). A flag stays set until software clears it.
- R9: A control write with a 1 in a flag bit clears that flag. A 0 in a flag bit leaves the flag unchanged. If a wrap happens in the same cycle as the clear, the flag stays set.
- R10: `irq` is high exactly when some flag is set together with its enable. The enables are bit 4 (event 0), bit 5 (event 1) and bit 6 (cycle).
- R11: Bits 7, 11 and 28-31 of the control word ignore writes and read as zero. Bits 0, 3, 4-6 and 12-27 read back as last written.
- R12: The address map is 0 = control, 1 = cycle counter, 2 = event counter 0, 3 = event counter 1. A write to a counter address loads that counter. The load takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| evt_in | input | EVT_CODES | One-cycle activity pulses, indexed by event code |
| irq | output | 1 | Wrap interrupt request |

## Verification
The bench runs counters up to the all-ones boundary so that a wrap happens. It then checks that the flag and `irq` follow the flag enables. It also checks that writing a zero to a flag leaves it set and writing a one clears it. A design that dropped flags on an unrelated write, or that ignored the enable gating, would show the wrong `irq` level. The bench loads a counter while it is running; if the increment won over the load, the read-back value would be off by one. Out-of-range event codes and the reserved control bits are exercised so that a decoder wrapping on index width or a register storing every bit would be caught. The slow-rate cycle count is checked against an exact edge count, which exposes a divider that is off by one or that is not cleared by the strobe.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NCNT    = 3;
  localparam int IDX_EV0 = 0;
  localparam int IDX_EV1 = 1;
  localparam int IDX_CYC = 2;

  // control word bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_CLREV = 1;
  localparam int CB_CLRCY = 2;
  localparam int CB_SLOW  = 3;
  localparam int CB_IE    = 4;   // 3 bits, counter index order
  localparam int CB_WRAP  = 8;   // 3 bits, counter index order
  localparam int CB_SEL0  = 12;
  localparam int CB_SEL1  = 20;
  localparam int SEL_W    = 8;

  // stored (non-strobe, non-flag, non-reserved) bits
  localparam logic [31:0] KEEP_MASK = 32'h0FFF_F079;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CYC  = 2'd1,
    RA_EV0  = 2'd2,
    RA_EV1  = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/pmon_evsel.sv
module pmon_evsel #(
  parameter int EVT_CODES = 23,
  parameter int SEL_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel,
  input  logic [EVT_CODES-1:0] evt,
  output logic                 hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < EVT_CODES; i++) begin
      if (sel == i[SEL_W-1:0]) hit = evt[i];
    end
  end

  // R7: codes past the event vector never count
  p_nocode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= SEL_W'(EVT_CODES)) |-> !hit);
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [W-1:0] q_n;
  logic         q_ce;

  always_comb begin
    q_ce = clr | load | inc;
    if (clr)       q_n = '0;
    else if (load) q_n = ld_val;
    else           q_n = q + 1'b1;
    wrap = inc & ~load & ~clr & (&q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ce) q <= q_n;
  end

  // R12: bus load wins over increment
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (q == $past(ld_val)));
  // R2: nothing to do means no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load && !clr) |=> $stable(q));
  // R8: all-ones step lands on zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !clr && (&q)) |=> (q == '0));
endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCNT-1:0]   wrap,
  output logic              run,
  output logic              slow,
  output logic              clr_ev,
  output logic              clr_cy,
  output logic [NCNT-1:0]   ie,
  output logic [NCNT-1:0]   flags,
  output logic [SEL_W-1:0]  sel0,
  output logic [SEL_W-1:0]  sel1,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] keep_q, keep_n;
  logic [NCNT-1:0]   flags_n, wclr;

  always_comb begin
    keep_n  = wr ? (wdata & DATA_W'(KEEP_MASK)) : keep_q;
    wclr    = wr ? wdata[CB_WRAP +: NCNT] : '0;
    flags_n = (flags & ~wclr) | wrap;
    clr_ev  = wr & wdata[CB_CLREV];
    clr_cy  = wr & wdata[CB_CLRCY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= '0;
      flags  <= '0;
    end else begin
      if (wr) keep_q <= keep_n;
      flags <= flags_n;
    end
  end

  assign run  = keep_q[CB_RUN];
  assign slow = keep_q[CB_SLOW];
  assign ie   = keep_q[CB_IE +: NCNT];
  assign sel0 = keep_q[CB_SEL0 +: SEL_W];
  assign sel1 = keep_q[CB_SEL1 +: SEL_W];

  always_comb begin
    word = keep_q;
    word[CB_WRAP +: NCNT] = flags;
  end

  // R9: a wrap always leaves its flag set, even against a clear
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((flags & $past(wrap)) == $past(wrap)));
  // R8: flags only drop through a control write
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
  import pmon_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int EVT_CODES = 23,
  parameter int DIV_LOG2  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [EVT_CODES-1:0] evt_in,
  output logic                 irq
);
  localparam int NSEL = 2;

  logic              run, slow, clr_ev, clr_cy;
  logic [NCNT-1:0]   ie, flags, wrap_v, inc_v, clr_v, ld_v;
  logic [SEL_W-1:0]  sel0, sel1;
  logic [SEL_W-1:0]  sel_v [NSEL];
  logic [NSEL-1:0]   hit_v;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] cnt_q [NCNT];
  logic [DIV_LOG2-1:0] pre_q, pre_n;
  logic              pre_ce, tick;

  pmon_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_we && (bus_addr == RA_CTRL)), .wdata(bus_wdata), .wrap(wrap_v),
    .run(run), .slow(slow), .clr_ev(clr_ev), .clr_cy(clr_cy),
    .ie(ie), .flags(flags), .sel0(sel0), .sel1(sel1), .word(word)
  );

  assign sel_v[IDX_EV0] = sel0;
  assign sel_v[IDX_EV1] = sel1;

  // rate divider for the slow cycle count
  always_comb begin
    pre_ce = clr_cy | (run & slow);
    pre_n  = clr_cy ? '0 : pre_q + 1'b1;
    tick   = &pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_ce) pre_q <= pre_n;
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    localparam logic [1:0] MY_ADR = (k == IDX_CYC) ? RA_CYC :
                                    (k == IDX_EV0) ? RA_EV0 : RA_EV1;
    if (k == IDX_CYC) begin : g_cyc
      assign inc_v[k] = run & (~slow | tick);
      assign clr_v[k] = clr_cy;
    end else begin : g_evt
      pmon_evsel #(.EVT_CODES(EVT_CODES), .SEL_W(SEL_W)) sel_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_v[k]), .evt(evt_in), .hit(hit_v[k])
      );
      assign inc_v[k] = run & hit_v[k];
      assign clr_v[k] = clr_ev;
    end
    assign ld_v[k] = bus_we && (bus_addr == MY_ADR);

    pmon_counter #(.W(DATA_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(clr_v[k]), .load(ld_v[k]),
      .ld_val(bus_wdata), .inc(inc_v[k]), .q(cnt_q[k]), .wrap(wrap_v[k])
    );
  end

  always_comb begin
    case (bus_addr)
      RA_CTRL: bus_rdata = word;
      RA_CYC:  bus_rdata = cnt_q[IDX_CYC];
      RA_EV0:  bus_rdata = cnt_q[IDX_EV0];
      default: bus_rdata = cnt_q[IDX_EV1];
    endcase
  end

  assign irq = |(flags & ie);

  // R11: reserved control bits never read as one
  p_resv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RA_CTRL) |-> (bus_rdata[7] == 1'b0 && bus_rdata[11] == 1'b0 &&
                               bus_rdata[31:28] == 4'h0));
  // R2: a stopped monitor leaves the cycle counter alone unless written
  p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_we) |=> $stable(cnt_q[IDX_CYC]));
endmodule

// File: tb/pmon_unit_tb_top.sv
`timescale 1ns/1ps
module pmon_unit_tb_top;
  localparam int DW = 32;
  localparam int NE = 23;

  logic          clk, rst_n, bus_we;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [NE-1:0] evt_in;
  logic          irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  pmon_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic [22:0] mask;
    logic [7:0]  n;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h05, 8'h07, 23'h000020,  8'd10, 32'd10, 32'd0},
    '{8'h07, 8'h05, 23'h0000A0,  8'd3,  32'd3,  32'd3},
    '{8'hFF, 8'h16, 23'h7FFFFF,  8'd7,  32'd0,  32'd7},
    '{8'h16, 8'h00, 23'h000001,  8'd4,  32'd0,  32'd4},
    '{8'h20, 8'h0A, 23'h7FFFFF,  8'd5,  32'd0,  32'd5},
    '{8'h0B, 8'h0B, 23'h000800,  8'd1,  32'd1,  32'd1}
  };

  function automatic logic [31:0] ctl(logic en, logic rev, logic rcy, logic slw,
                                      logic [2:0] ie, logic [2:0] wc,
                                      logic [7:0] s0, logic [7:0] s1);
    return {4'h0, s1, s0, 1'b0, wc, 1'b0, ie, slw, rcy, rev, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called in the low phase; spans one rising edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdreg(logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdreg(a[1:0], rd); check("R1", rd, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R6 / R7 vector table
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 3'b0, VECS[v].s0, VECS[v].s1));
      wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 3'b0, 3'b0, VECS[v].s0, VECS[v].s1));
      evt_in = VECS[v].mask;
      repeat (VECS[v].n) @(negedge clk);
      evt_in = '0;
      wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 3'b0, VECS[v].s0, VECS[v].s1));
      rdreg(2'd2, rd); check("R6/R7 ev0", rd, VECS[v].e0);
      rdreg(2'd3, rd); check("R6/R7 ev1", rd, VECS[v].e1);
    end

    // R2 run clear: nothing moves
    wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 3'b0, 8'h05, 8'h05));
    rdreg(2'd1, rd);
    begin
      logic [31:0] cyc0;
      cyc0 = rd;
      evt_in = 23'h000020;
      repeat (5) @(negedge clk);
      evt_in = '0;
      rdreg(2'd2, rd); check("R2 ev0", rd, 32'h0);
      rdreg(2'd1, rd); check("R2 cyc", rd, cyc0);
    end

    // R3 strobes clear their own group only
    wr(2'd2, 32'h55); wr(2'd3, 32'h66); wr(2'd1, 32'h77);
    wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 3'b0, 8'hFF, 8'hFF));
    rdreg(2'd2, rd); check("R3 ev0", rd, 32'h0);
    rdreg(2'd3, rd); check("R3 ev1", rd, 32'h0);
    rdreg(2'd1, rd); check("R3 cyc kept", rd, 32'h77);
    rdreg(2'd0, rd); check("R3 strobe reads 0", rd & 32'h6, 32'h0);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 3'b0, 8'hFF, 8'hFF));
    rdreg(2'd1, rd); check("R3 cyc", rd, 32'h0);

    // R4 full-rate cycle count: 10 run edges
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 3'b0, 3'b0, 8'hFF, 8'hFF));
    repeat (9) @(negedge clk);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 3'b0, 8'hFF, 8'hFF));
    rdreg(2'd1, rd); check("R4", rd, 32'd10);

    // R5 slow count: 130 run edges -> 2
    wr(2'd0, ctl(1'b0, 1'b0, 1'b1, 1'b1, 3'b0, 3'b0, 8'hFF, 8'hFF));
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b1, 3'b0, 3'b0, 8'hFF, 8'hFF));
    repeat (129) @(negedge clk);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b1, 3'b0, 3'b0, 8'hFF, 8'hFF));
    rdreg(2'd1, rd); check("R5", rd, 32'd2);

    // R12 load beats increment while running
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 3'b0, 3'b0, 8'hFF, 8'hFF));
    wr(2'd1, 32'h100);
    rdreg(2'd1, rd); check("R12 load", rd, 32'h100);
    @(negedge clk);
    rdreg(2'd1, rd); check("R12 after", rd, 32'h101);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 3'b0, 8'hFF, 8'hFF));

    // R8 / R9 / R10 event counter 0 wrap
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 3'b001, 3'b0, 8'h01, 8'hFF));
    evt_in = 23'h000002;
    repeat (2) @(negedge clk);
    evt_in = '0;
    #1;
    check("R10 irq on", {31'b0, irq}, 32'h1);
    rdreg(2'd2, rd); check("R8 ev0 wrapped", rd, 32'h0);
    rdreg(2'd0, rd); check("R8 flag", rd & 32'h700, 32'h100);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 3'b000, 8'h01, 8'hFF));
    rdreg(2'd0, rd); check("R9 zero keeps", rd & 32'h700, 32'h100);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 8'h01, 8'hFF));
    #1; check("R10 gated", {31'b0, irq}, 32'h0);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001, 8'h01, 8'hFF));
    rdreg(2'd0, rd); check("R9 cleared", rd & 32'h700, 32'h0);
    #1; check("R9 irq off", {31'b0, irq}, 32'h0);

    // R8 / R10 cycle counter wrap
    wr(2'd1, 32'hFFFF_FFFD);
    wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 3'b100, 3'b0, 8'hFF, 8'hFF));
    repeat (2) @(negedge clk);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 3'b0, 8'hFF, 8'hFF));
    rdreg(2'd1, rd); check("R8 cyc wrapped", rd, 32'h0);
    rdreg(2'd0, rd); check("R8 cyc flag", rd & 32'h700, 32'h400);
    #1; check("R10 cyc irq", {31'b0, irq}, 32'h1);
    wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 3'b100, 8'hFF, 8'hFF));
    #1; check("R9 cyc clear", {31'b0, irq}, 32'h0);

    // R11 reserved bits and read-back
    wr(2'd0, 32'hFFFF_FFFF);
    rdreg(2'd0, rd); check("R11 readback", rd, 32'h0FFF_F079);
    wr(2'd0, 32'h0);
    rdreg(2'd0, rd); check("R11 zero", rd, 32'h0);

    finish_run();
  end
endmodule